// File: doc/BRIEF.md
# Rotating Sliced Integer ALU

A 64-bit integer ALU datapath built from six independent slices: four 8-bit slices (slices 0 to 3) and two 16-bit slices (slices 4 and 5). Each request is routed to the smallest set of slices that covers its operand width. The slices a request does not need are held disabled, with their operands forced to zero. This models a power-gate that lets their PMOS devices recover from bias stress. When no request is valid, every slice is disabled.

Narrow requests are common, so a round-robin allocator spreads them over the slices. A 2-bit byte pointer picks one of the four 8-bit slices for each 8-bit request. A 1-bit half pointer picks one of the two 16-bit slices for each 16-bit request. A two-state grouping machine alternates 32-bit requests between a chain of the four byte slices (state `GRP_BYTES`) and a chain of the two half slices (state `GRP_HALVES`). The transitions are:

- `GRP_BYTES` to `GRP_HALVES` when a 32-bit request is accepted.
- `GRP_HALVES` back to `GRP_BYTES` on the next 32-bit request.
- Any other request leaves the state unchanged.

A 64-bit request chains all six slices. The carry ripples through the byte slices in order, then through slice 4, then through slice 5. Inside every slice, the sum is formed by a parallel-prefix (Kogge-Stone) carry network. The result, carry and slice enables are registered.

Top module: `nbti_slice_alu`

## Requirements
- R1: After reset, `res_valid`, `result`, `carry_out` and `slice_gate` are zero. The byte pointer, the half pointer and the grouping state start at slice 0, slice 4 and `GRP_BYTES` respectively.
- R2: In the cycle after one where `op_valid` is low, `slice_gate` is all zero.
- R3: An 8-bit request (`width_sel`=0) enables exactly one byte slice, `slice_gate` bit 0 to 3. Successive 8-bit requests use slices 0, 1, 2, 3, 0, and so on.
- R4: A 16-bit request (`width_sel`=1) enables exactly one half slice. Successive 16-bit requests alternate between slice 4 (bit 4) and slice 5 (bit 5).
- R5: A 32-bit request (`width_sel`=2) alternates between the gate pattern 6'b001111 and the gate pattern 6'b110000. The first 32-bit request after reset uses 6'b001111.
- R6: A 64-bit request (`width_sel`=3) enables all six slices (6'b111111).
- R7: A pointer or grouping state advances only on a valid request of its own width. Requests of other widths and idle cycles leave it unchanged.
- R8: Arithmetic opcodes are add (0) and subtract (1), and codes 5 to 7 act as add. `result` equals the operands masked to the selected width, summed modulo 2^width. Subtract is computed as a + ~b + 1. `carry_out` is the carry out of the top bit of the width, so for subtract 1 means no borrow. This holds whatever the allocator state.
- R9: The logical opcodes are AND (2), OR (3) and XOR (4). They give the bitwise result at the selected width, and `carry_out` is 0.
- R10: `result` bits above the selected width are zero, whatever the operand bits above that width.
- R11: `res_valid` repeats `op_valid` one cycle later. `result`, `carry_out` and `slice_gate` for a request appear in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request strobe |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| opcode | input | 3 | 0 add, 1 sub, 2 and, 3 or, 4 xor, 5-7 add |
| width_sel | input | 2 | 0: 8, 1: 16, 2: 32, 3: 64 bits |
| res_valid | output | 1 | Registered request strobe |
| result | output | 64 | Registered zero-extended result |
| carry_out | output | 1 | Registered carry out of the width's top bit |
| slice_gate | output | 6 | Registered slice enables, bits 0-3 byte slices, 4-5 half slices |

## Verification
- **Carry chains:** directed 8-bit adds with garbage in the upper operand bits, and an all-ones 64-bit increment, exercise the full carry chain. Together they separate a broken byte-to-half carry hand-off from a missing zero-extension.
- **Width mixing:** requests of several widths are interleaved with idle cycles. This separates a pointer that moves on any request from one that moves only on its own width, because the next gate pattern then lands on the wrong slice.
- **Borrow propagation:** subtractions that borrow across slice boundaries, in both 32-bit groupings, check that the inverted operand and the carry-in of 1 enter only the lowest slice of a chain.
- **Random traffic:** a long stream of random opcodes, widths and gaps is compared each clock against a behavioural model that knows nothing of slices. This shows the result does not depend on which slices served a request.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int BYTE_W   = 8;
    localparam int HALF_W   = 16;
    localparam int N_BYTE   = 4;
    localparam int N_HALF   = 2;
    localparam int N_SLICE  = N_BYTE + N_HALF;
    localparam int DATA_W   = N_BYTE * BYTE_W + N_HALF * HALF_W;
    localparam int BPTR_W   = $clog2(N_BYTE);
    localparam int HPTR_W   = $clog2(N_HALF);

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        WD_8  = 2'd0,
        WD_16 = 2'd1,
        WD_32 = 2'd2,
        WD_64 = 2'd3
    } width_e;

    typedef enum logic {
        GRP_BYTES  = 1'b0,
        GRP_HALVES = 1'b1
    } grp32_e;

endpackage

// File: rtl/ks_slice.sv
module ks_slice
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         en_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic [2:0]   op_i,
    output logic [W-1:0] res_o,
    output logic         co_o
);

    logic         is_sub;
    logic         is_logic;
    logic [W-1:0] a_g;
    logic [W-1:0] b_g;
    logic [W-1:0] b_arith;
    logic         c_g;
    logic [W-1:0] gen;
    logic [W-1:0] prp;
    logic [W-1:0] g_cur;
    logic [W-1:0] p_cur;
    logic [W-1:0] g_nxt;
    logic [W-1:0] p_nxt;
    logic [W-1:0] carries;
    logic [W-1:0] sum;

    assign is_sub   = (op_i == OP_SUB);
    assign is_logic = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR);

    // gated slice: a disabled slice sees only zeros
    assign a_g     = en_i ? a_i : '0;
    assign b_g     = en_i ? b_i : '0;
    assign b_arith = is_sub ? ~b_g : b_g;
    assign c_g     = en_i & cin_i;

    assign gen = a_g & b_arith;
    assign prp = a_g ^ b_arith;

    // parallel-prefix carry network, span doubles each level
    always_comb begin
        g_cur    = gen;
        p_cur    = prp;
        g_cur[0] = gen[0] | (prp[0] & c_g);
        g_nxt    = g_cur;
        p_nxt    = p_cur;
        for (int d = 1; d < W; d = d * 2) begin
            g_nxt = g_cur;
            p_nxt = p_cur;
            for (int i = 0; i < W; i++) begin
                if (i >= d) begin
                    g_nxt[i] = g_cur[i] | (p_cur[i] & g_cur[i-d]);
                    p_nxt[i] = p_cur[i] & p_cur[i-d];
                end
            end
            g_cur = g_nxt;
            p_cur = p_nxt;
        end
    end

    assign carries = {g_cur[W-2:0], c_g};
    assign sum     = prp ^ carries;

    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_g & b_g;
            OP_OR:   res_o = a_g | b_g;
            OP_XOR:  res_o = a_g ^ b_g;
            default: res_o = sum;
        endcase
        co_o = is_logic ? 1'b0 : g_cur[W-1];
    end

endmodule

// File: rtl/rr_alloc.sv
module rr_alloc
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [1:0]        width_i,
    output logic [BPTR_W-1:0] byte_ptr_o,
    output logic [HPTR_W-1:0] half_ptr_o,
    output grp32_e            grp_o,
    output logic [N_SLICE-1:0] gate_o
);

    logic [BPTR_W-1:0] byte_ptr_q;
    logic [HPTR_W-1:0] half_ptr_q;
    grp32_e            grp_q;
    grp32_e            grp_d;
    width_e            wd;

    assign wd = width_e'(width_i);

    always_comb begin
        grp_d = grp_q;
        if (valid_i && wd == WD_32) begin
            unique case (grp_q)
                GRP_BYTES:  grp_d = GRP_HALVES;
                GRP_HALVES: grp_d = GRP_BYTES;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_ptr_q <= '0;
            half_ptr_q <= '0;
            grp_q      <= GRP_BYTES;
        end else begin
            grp_q <= grp_d;
            if (valid_i && wd == WD_8)  byte_ptr_q <= byte_ptr_q + 1'b1;
            if (valid_i && wd == WD_16) half_ptr_q <= half_ptr_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        gate_o = '0;
        if (valid_i) begin
            unique case (wd)
                WD_8:  gate_o[byte_ptr_q] = 1'b1;
                WD_16: gate_o[N_BYTE + int'(half_ptr_q)] = 1'b1;
                WD_32: gate_o = (grp_q == GRP_BYTES) ?
                                {{N_HALF{1'b0}}, {N_BYTE{1'b1}}} :
                                {{N_HALF{1'b1}}, {N_BYTE{1'b0}}};
                WD_64: gate_o = '1;
            endcase
        end
    end

    assign byte_ptr_o = byte_ptr_q;
    assign half_ptr_o = half_ptr_q;
    assign grp_o      = grp_q;

    assert_byte_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && wd == WD_8) |=> byte_ptr_q == BPTR_W'($past(byte_ptr_q) + 1'b1));

    assert_half_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && wd == WD_16) |=> half_ptr_q != $past(half_ptr_q));

    assert_group_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && wd == WD_32) |=> grp_q != $past(grp_q));

    assert_byte_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && wd == WD_8) |=> $stable(byte_ptr_q));

    assert_half_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && wd == WD_16) |=> $stable(half_ptr_q));

    assert_group_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && wd == WD_32) |=> $stable(grp_q));

endmodule

// File: rtl/nbti_slice_alu.sv
module nbti_slice_alu
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [2:0]        opcode,
    input  logic [1:0]        width_sel,
    output logic              res_valid,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic [N_SLICE-1:0] slice_gate
);

    localparam int BYTES_W = N_BYTE * BYTE_W;

    logic [BPTR_W-1:0]  byte_ptr;
    logic [HPTR_W-1:0]  half_ptr;
    grp32_e             grp;
    logic [N_SLICE-1:0] gate;
    width_e             wd;
    logic               cin0;

    logic [N_BYTE-1:0][BYTE_W-1:0] a_b, b_b, sum_b;
    logic [N_HALF-1:0][HALF_W-1:0] a_h, b_h, sum_h;
    logic [N_BYTE-1:0] start_b, chain_b, co_b;
    logic [N_HALF-1:0] start_h, chain_h, co_h;

    logic [DATA_W-1:0] res_d;
    logic              co_d;

    assign wd   = width_e'(width_sel);
    assign cin0 = (opcode == OP_SUB);

    rr_alloc u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (op_valid),
        .width_i    (width_sel),
        .byte_ptr_o (byte_ptr),
        .half_ptr_o (half_ptr),
        .grp_o      (grp),
        .gate_o     (gate)
    );

    // operand routing and carry chaining
    always_comb begin
        a_b = '0; b_b = '0; start_b = '0; chain_b = '0;
        a_h = '0; b_h = '0; start_h = '0; chain_h = '0;
        unique case (wd)
            WD_8: begin
                a_b[byte_ptr]     = opnd_a[BYTE_W-1:0];
                b_b[byte_ptr]     = opnd_b[BYTE_W-1:0];
                start_b[byte_ptr] = cin0;
            end
            WD_16: begin
                a_h[half_ptr]     = opnd_a[HALF_W-1:0];
                b_h[half_ptr]     = opnd_b[HALF_W-1:0];
                start_h[half_ptr] = cin0;
            end
            WD_32: begin
                if (grp == GRP_BYTES) begin
                    a_b = opnd_a[BYTES_W-1:0];
                    b_b = opnd_b[BYTES_W-1:0];
                    start_b[0] = cin0;
                    chain_b    = {{(N_BYTE-1){1'b1}}, 1'b0};
                end else begin
                    a_h = opnd_a[N_HALF*HALF_W-1:0];
                    b_h = opnd_b[N_HALF*HALF_W-1:0];
                    start_h[0] = cin0;
                    chain_h    = {{(N_HALF-1){1'b1}}, 1'b0};
                end
            end
            WD_64: begin
                a_b = opnd_a[BYTES_W-1:0];
                b_b = opnd_b[BYTES_W-1:0];
                a_h = opnd_a[DATA_W-1:BYTES_W];
                b_h = opnd_b[DATA_W-1:BYTES_W];
                start_b[0] = cin0;
                chain_b    = {{(N_BYTE-1){1'b1}}, 1'b0};
                chain_h    = '1;
            end
        endcase
    end

    for (genvar k = 0; k < N_BYTE; k++) begin : g_byte
        logic              cin;
        logic              co;
        logic [BYTE_W-1:0] sum;
        if (k == 0) begin : g_first
            assign cin = start_b[k];
        end else begin : g_next
            assign cin = chain_b[k] ? g_byte[k-1].co : start_b[k];
        end
        ks_slice #(.W(BYTE_W)) u_slice (
            .en_i  (gate[k]),
            .a_i   (a_b[k]),
            .b_i   (b_b[k]),
            .cin_i (cin),
            .op_i  (opcode),
            .res_o (sum),
            .co_o  (co)
        );
        assign sum_b[k] = sum;
        assign co_b[k]  = co;
    end

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        logic              cin;
        logic              co;
        logic [HALF_W-1:0] sum;
        if (h == 0) begin : g_first
            assign cin = chain_h[h] ? g_byte[N_BYTE-1].co : start_h[h];
        end else begin : g_next
            assign cin = chain_h[h] ? g_half[h-1].co : start_h[h];
        end
        ks_slice #(.W(HALF_W)) u_slice (
            .en_i  (gate[N_BYTE + h]),
            .a_i   (a_h[h]),
            .b_i   (b_h[h]),
            .cin_i (cin),
            .op_i  (opcode),
            .res_o (sum),
            .co_o  (co)
        );
        assign sum_h[h] = sum;
        assign co_h[h]  = co;
    end

    // result assembly, zero-extended above the width
    always_comb begin
        res_d = '0;
        co_d  = 1'b0;
        unique case (wd)
            WD_8: begin
                res_d[BYTE_W-1:0] = sum_b[byte_ptr];
                co_d              = co_b[byte_ptr];
            end
            WD_16: begin
                res_d[HALF_W-1:0] = sum_h[half_ptr];
                co_d              = co_h[half_ptr];
            end
            WD_32: begin
                if (grp == GRP_BYTES) begin
                    res_d[BYTES_W-1:0] = sum_b;
                    co_d               = co_b[N_BYTE-1];
                end else begin
                    res_d[N_HALF*HALF_W-1:0] = sum_h;
                    co_d                     = co_h[N_HALF-1];
                end
            end
            WD_64: begin
                res_d = {sum_h, sum_b};
                co_d  = co_h[N_HALF-1];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            result     <= '0;
            carry_out  <= 1'b0;
            slice_gate <= '0;
        end else begin
            res_valid  <= op_valid;
            slice_gate <= gate;
            if (op_valid) begin
                result    <= res_d;
                carry_out <= co_d;
            end
        end
    end

    assert_idle_gates_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> slice_gate == '0);

    assert_byte_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && wd == WD_8) |=>
            ($countones(slice_gate) == 1 && slice_gate[N_SLICE-1:N_BYTE] == '0));

    assert_half_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && wd == WD_16) |=>
            ($countones(slice_gate) == 1 && slice_gate[N_BYTE-1:0] == '0));

    assert_full_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && wd == WD_64) |=> slice_gate == '1);

    assert_logic_no_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (opcode == OP_AND || opcode == OP_OR || opcode == OP_XOR))
            |=> !carry_out);

    assert_zero_ext_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && wd == WD_8) |=> result[DATA_W-1:BYTE_W] == '0);

    assert_zero_ext_half_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && wd == WD_16) |=> result[DATA_W-1:HALF_W] == '0);

    assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> res_valid == $past(op_valid));

endmodule

// File: tb/nbti_slice_alu_tb.sv
module nbti_slice_alu_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [63:0] opnd_a, opnd_b;
    logic [2:0]  opcode;
    logic [1:0]  width_sel;
    logic        res_valid;
    logic [63:0] result;
    logic        carry_out;
    logic [5:0]  slice_gate;

    always #(CLK_PERIOD/2) clk = ~clk;

    nbti_slice_alu u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opcode(opcode), .width_sel(width_sel),
        .res_valid(res_valid), .result(result), .carry_out(carry_out),
        .slice_gate(slice_gate)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural model state
    int m_p8  = 0;
    int m_p16 = 0;
    int m_grp = 0;
    bit          pend_v = 0;
    logic [63:0] pend_res;
    logic        pend_co;
    logic [5:0]  pend_gate;
    string       pend_rtag, pend_gtag;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic verify_pending();
        check("R11 res_valid", {63'd0, res_valid}, {63'd0, pend_v});
        if (pend_v) begin
            check(pend_rtag, result, pend_res);
            check({pend_rtag, " carry"}, {63'd0, carry_out}, {63'd0, pend_co});
            check(pend_gtag, {58'd0, slice_gate}, {58'd0, pend_gate});
        end else begin
            check("R2 idle gates", {58'd0, slice_gate}, 64'd0);
        end
    endtask

    task automatic cyc(bit v, logic [63:0] a, logic [63:0] b, logic [2:0] op, logic [1:0] w);
        int          bits;
        logic [63:0] mask, am, bm;
        logic [64:0] full;
        bit          is_logic;
        @(negedge clk);
        verify_pending();
        op_valid = v; opnd_a = a; opnd_b = b; opcode = op; width_sel = w;
        pend_v = v;
        if (v) begin
            bits = 8 << w;
            mask = (bits == 64) ? '1 : ((64'd1 << bits) - 64'd1);
            am = a & mask;
            bm = b & mask;
            is_logic = (op == 3'd2) || (op == 3'd3) || (op == 3'd4);
            full = '0;
            case (op)
                3'd1:    full = {1'b0, am} + {1'b0, (~bm) & mask} + 65'd1;
                3'd2:    full = {1'b0, am & bm};
                3'd3:    full = {1'b0, am | bm};
                3'd4:    full = {1'b0, am ^ bm};
                default: full = {1'b0, am} + {1'b0, bm};
            endcase
            pend_res = full[63:0] & mask;
            pend_co  = is_logic ? 1'b0 : full[bits];
            pend_rtag = is_logic ? "R9 logic result" : "R8 arith result";
            if (w != 2'd3) pend_rtag = {pend_rtag, " R10"};
            case (w)
                2'd0: begin
                    pend_gate = 6'd1 << m_p8; m_p8 = (m_p8 + 1) % 4;
                    pend_gtag = "R1 R3 R7 byte gate";
                end
                2'd1: begin
                    pend_gate = 6'd1 << (4 + m_p16); m_p16 = 1 - m_p16;
                    pend_gtag = "R1 R4 R7 half gate";
                end
                2'd2: begin
                    pend_gate = (m_grp != 0) ? 6'b110000 : 6'b001111; m_grp = 1 - m_grp;
                    pend_gtag = "R1 R5 R7 group gate";
                end
                default: begin
                    pend_gate = 6'b111111;
                    pend_gtag = "R6 full gate";
                end
            endcase
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; opnd_a = '0; opnd_b = '0; opcode = '0; width_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check("R1 reset res_valid", {63'd0, res_valid}, 64'd0);
        check("R1 reset result", result, 64'd0);
        check("R1 reset carry", {63'd0, carry_out}, 64'd0);
        check("R1 reset gate", {58'd0, slice_gate}, 64'd0);

        // R8 R10: 8-bit carry with garbage above the width
        cyc(1, 64'hDEAD_BEEF_0000_00FF, 64'hFFFF_0000_1234_0001, 3'd0, 2'd0);
        // R7: 16-bit and idle between byte ops
        cyc(1, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001, 3'd0, 2'd1);
        cyc(0, '0, '0, 3'd0, 2'd0);
        cyc(1, 64'h3, 64'h5, 3'd1, 2'd0);   // borrow: FE carry 0
        cyc(1, 64'h80, 64'h80, 3'd0, 2'd0);
        cyc(1, 64'h7F, 64'h01, 3'd6, 2'd0); // reserved acts as add
        cyc(1, 64'hAA, 64'h0F, 3'd4, 2'd0); // wrap back to slice 0
        cyc(1, 64'h1234, 64'h1234, 3'd1, 2'd1);
        cyc(1, 64'hFFFF, 64'h0F0F, 3'd2, 2'd1);
        // R5: groupings with cross-slice borrow
        cyc(1, 64'h0000_0100, 64'h1, 3'd1, 2'd2);
        cyc(1, 64'h0001_0000, 64'h1, 3'd1, 2'd2);
        cyc(0, '0, '0, 3'd0, 2'd0);
        cyc(1, 64'hFFFF_FFFF, 64'h1, 3'd0, 2'd2);
        // R6: full chain increment
        cyc(1, '1, 64'h1, 3'd0, 2'd3);
        cyc(1, 64'h0, 64'h1, 3'd1, 2'd3);
        cyc(1, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 3'd3, 2'd3);
        cyc(1, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 3'd0, 2'd3);

        // random traffic
        for (int n = 0; n < 600; n++) begin
            bit v;
            v = ($urandom_range(0, 3) != 0);
            cyc(v, {$urandom, $urandom}, {$urandom, $urandom},
                3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)));
        end
        cyc(0, '0, '0, 3'd0, 2'd0);
        cyc(0, '0, '0, 3'd0, 2'd0);
        finish_run();
    end

endmodule